// File: doc/BRIEF.md
# Click-Free Stereo Volume Ramp with Soft Mute

This block scales a stream of stereo audio sample pairs by a linear gain that is held separately for each channel. Software (or a control-port decoder in front of the block) asks for a new 14-bit gain per channel with a write strobe. The gain applied to the audio does not jump to the new value. Its coarse part, the upper 10 bits, slews by one count on each sample-rate strobe until it reaches the request. Its fine part, the lower 4 bits, is taken at once. This keeps large volume steps free of audible clicks. A full swing from one end of the range to the other takes 1023 sample periods.

A single mute request acts on both channels. It drives the coarse gain of each channel down to zero over the same ramp. Releasing mute ramps each channel back up to the gain it last requested. Samples arrive and leave over a valid/ready handshake with one register stage. An upstream source may hold data on the input while `in_ready` is low. A downstream sink may stall the output by holding `out_ready` low, and the output pair then stays frozen until it is taken. The current gain of each channel is visible on its own output.

Top module: `svol_stereo`

## Requirements
- R1: After reset both gain outputs read 0x3FFF (full scale), `out_valid` is 0 and `in_ready` is 1.
- R2: The upper 10 bits of a channel's gain (gain[13:4]) change only on a clock edge where `fs_tick` is 1. On such an edge they move one count toward the target that was held before that edge.
- R3: A write sets the lower 4 bits of that channel's gain (gain[3:0]) to request bits [3:0] on the next clock edge, with no `fs_tick` needed, unless mute is requested.
- R4: When gain[13:4] equals the target's upper 10 bits, further `fs_tick` pulses leave it unchanged, so there is no overshoot.
- R5: A write that arrives during a ramp retargets the ramp. The next step starts from the current gain and heads toward the new target, reversing direction if needed.
- R6: `vol_wr_l` changes only the left gain and `vol_wr_r` changes only the right gain. The two channels ramp independently.
- R7: While `mute_req` is 1, gain[3:0] of both channels is 0 from the next clock edge on. Gain[13:4] ramps toward 0 at one count per `fs_tick` and never rises, so a ramp from 0x3FF reaches 0 after exactly 1023 ticks.
- R8: When `mute_req` returns to 0, gain[3:0] takes the requested low bits back on the next edge. Gain[13:4] ramps back up to the requested upper bits.
- R9: Each output sample equals floor(x * g / 2^14). Here x is the 24-bit two's-complement input sample, g is the unsigned gain shown on that channel's gain port in the cycle the pair is accepted, and floor rounds toward minus infinity.
- R10: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1. An accepted pair appears on the outputs with `out_valid` after one clock edge. While `out_valid` is 1 and `out_ready` is 0, the output data and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vol_wr_l | input | 1 | Write strobe for the left gain request |
| vol_wr_r | input | 1 | Write strobe for the right gain request |
| vol_req_l | input | 14 | Requested left gain |
| vol_req_r | input | 14 | Requested right gain |
| fs_tick | input | 1 | One-cycle pulse once per sample period |
| mute_req | input | 1 | Mute request for both channels |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Block can take an input pair |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Sink takes the output pair |
| out_l | output | 24 | Left scaled sample, signed |
| out_r | output | 24 | Right scaled sample, signed |
| gain_l | output | 14 | Left gain in use |
| gain_r | output | 14 | Right gain in use |

## Verification
The bench builds the block with its default widths: a 14-bit gain split into 10 ramped bits and 4 immediate bits, and 24-bit samples. With these values a complete mute ramp from 0x3FF down to 0, and the return climb, each fit in roughly two thousand cycles. The exact 1023-tick length and the stop at zero can therefore be checked count for count. The 24-bit width also puts both signed extremes, 0x7FFFFF and 0x800000, within reach, which tests floor rounding at full scale.

// File: rtl/svol_pkg.sv
package svol_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_L = 1'b0, CH_R = 1'b1} chan_e;
endpackage

// File: rtl/svol_slew.sv
module svol_slew #(
  parameter int GW = 14,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [GW-1:0] req,
  input  logic          tick,
  input  logic          mute,
  output logic [GW-1:0] gain
);
  localparam int LW = GW - RW;

  logic [GW-1:0] tgt;
  logic [RW-1:0] hi;
  logic [LW-1:0] lo;
  logic [RW-1:0] goal;

  // coarse goal: zero while muted, otherwise the held request
  always_comb goal = mute ? '0 : tgt[GW-1:LW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt <= '1;
      hi  <= '1;
      lo  <= '1;
    end else begin
      if (wr) tgt <= req;
      if (mute)    lo <= '0;
      else if (wr) lo <= req[LW-1:0];
      else         lo <= tgt[LW-1:0];
      if (tick) begin
        if (hi < goal)      hi <= hi + 1'b1;
        else if (hi > goal) hi <= hi - 1'b1;
      end
    end
  end

  assign gain = {hi, lo};
endmodule

// File: rtl/svol_scale.sv
module svol_scale #(
  parameter int SW = 24,
  parameter int GW = 14
) (
  input  logic [SW-1:0] din,
  input  logic [GW-1:0] gain,
  output logic [SW-1:0] dout
);
  logic signed [SW+GW:0] prod;

  always_comb begin
    prod = $signed(din) * $signed({1'b0, gain});
    dout = SW'(prod >>> GW);
  end
endmodule

// File: rtl/svol_stage.sv
module svol_stage #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/svol_stereo.sv
module svol_stereo #(
  parameter int GAIN_W   = 14,
  parameter int RAMP_W   = 10,
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vol_wr_l,
  input  logic                vol_wr_r,
  input  logic [GAIN_W-1:0]   vol_req_l,
  input  logic [GAIN_W-1:0]   vol_req_r,
  input  logic                fs_tick,
  input  logic                mute_req,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r,
  output logic [GAIN_W-1:0]   gain_l,
  output logic [GAIN_W-1:0]   gain_r
);
  import svol_pkg::*;

  localparam int PAIR_W = SAMPLE_W * NUM_CH;

  logic                wr_a     [NUM_CH];
  logic [GAIN_W-1:0]   req_a    [NUM_CH];
  logic [GAIN_W-1:0]   gain_a   [NUM_CH];
  logic [SAMPLE_W-1:0] smp_a    [NUM_CH];
  logic [SAMPLE_W-1:0] scaled_a [NUM_CH];
  logic [PAIR_W-1:0]   pair_in;
  logic [PAIR_W-1:0]   pair_out;

  assign wr_a[CH_L]  = vol_wr_l;
  assign wr_a[CH_R]  = vol_wr_r;
  assign req_a[CH_L] = vol_req_l;
  assign req_a[CH_R] = vol_req_r;
  assign smp_a[CH_L] = in_l;
  assign smp_a[CH_R] = in_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    svol_slew #(.GW(GAIN_W), .RW(RAMP_W)) slew_i (
      .clk  (clk),
      .rst_n(rst_n),
      .wr   (wr_a[c]),
      .req  (req_a[c]),
      .tick (fs_tick),
      .mute (mute_req),
      .gain (gain_a[c])
    );
    svol_scale #(.SW(SAMPLE_W), .GW(GAIN_W)) scale_i (
      .din (smp_a[c]),
      .gain(gain_a[c]),
      .dout(scaled_a[c])
    );
    assign pair_in[c*SAMPLE_W +: SAMPLE_W] = scaled_a[c];
  end

  svol_stage #(.W(PAIR_W)) stage_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_valid(in_valid),
    .s_ready(in_ready),
    .s_data (pair_in),
    .m_valid(out_valid),
    .m_ready(out_ready),
    .m_data (pair_out)
  );

  assign out_l  = pair_out[CH_L*SAMPLE_W +: SAMPLE_W];
  assign out_r  = pair_out[CH_R*SAMPLE_W +: SAMPLE_W];
  assign gain_l = gain_a[CH_L];
  assign gain_r = gain_a[CH_R];
endmodule

// File: rtl/svol_stereo_chk.sv
module svol_stereo_chk #(
  parameter int GAIN_W   = 14,
  parameter int RAMP_W   = 10,
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fs_tick,
  input logic                mute_req,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_l,
  input logic [SAMPLE_W-1:0] out_r,
  input logic [GAIN_W-1:0]   gain_l,
  input logic [GAIN_W-1:0]   gain_r
);
  localparam int LW = GAIN_W - RAMP_W;

  logic [RAMP_W-1:0] hi_l, hi_r;
  assign hi_l = gain_l[GAIN_W-1:LW];
  assign hi_r = gain_r[GAIN_W-1:LW];

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_tick |=> ($stable(hi_l) && $stable(hi_r))); // R2

  AST_ONE_STEP_L: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tick |=> (hi_l == $past(hi_l) || hi_l == $past(hi_l) + 1'b1 || hi_l == $past(hi_l) - 1'b1)); // R2

  AST_ONE_STEP_R: assert property (@(posedge clk) disable iff (!rst_n)
    fs_tick |=> (hi_r == $past(hi_r) || hi_r == $past(hi_r) + 1'b1 || hi_r == $past(hi_r) - 1'b1)); // R2

  AST_MUTE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> (hi_l <= $past(hi_l) && hi_r <= $past(hi_r))); // R7

  AST_MUTE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |=> (gain_l[LW-1:0] == '0 && gain_r[LW-1:0] == '0)); // R7

  AST_MUTE_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_req && hi_l == '0 && hi_r == '0) |=> (hi_l == '0 && hi_r == '0)); // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_l) && $stable(out_r))); // R10
endmodule

bind svol_stereo svol_stereo_chk #(
  .GAIN_W(GAIN_W), .RAMP_W(RAMP_W), .SAMPLE_W(SAMPLE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .mute_req(mute_req),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_l(out_l), .out_r(out_r), .gain_l(gain_l), .gain_r(gain_r)
);

// File: tb/svol_stereo_tb_top.sv
module svol_stereo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vol_wr_l = 1'b0, vol_wr_r = 1'b0;
  logic [13:0] vol_req_l = '0, vol_req_r = '0;
  logic        fs_tick = 1'b0, mute_req = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [23:0] in_l = '0, in_r = '0;
  logic        in_ready, out_valid;
  logic [23:0] out_l, out_r;
  logic [13:0] gain_l, gain_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  svol_stereo dut_i (
    .clk(clk), .rst_n(rst_n), .vol_wr_l(vol_wr_l), .vol_wr_r(vol_wr_r),
    .vol_req_l(vol_req_l), .vol_req_r(vol_req_r), .fs_tick(fs_tick),
    .mute_req(mute_req), .in_valid(in_valid), .in_ready(in_ready),
    .in_l(in_l), .in_r(in_r), .out_valid(out_valid), .out_ready(out_ready),
    .out_l(out_l), .out_r(out_r), .gain_l(gain_l), .gain_r(gain_r)
  );

  // {in_l, in_r, expected out_l, expected out_r} at full-scale gain 0x3FFF
  localparam logic [95:0] VEC [8] = '{
    {24'h004000, 24'hFFC000, 24'h003FFF, 24'hFFC001},
    {24'h000000, 24'h000001, 24'h000000, 24'h000000},
    {24'hFFFFFF, 24'h7FFFFF, 24'hFFFFFF, 24'h7FFDFF},
    {24'h800000, 24'h0186A0, 24'h800200, 24'h018699},
    {24'h400000, 24'hC00000, 24'h3FFF00, 24'hC00100},
    {24'h000002, 24'hFFFFFE, 24'h000001, 24'hFFFFFE},
    {24'h00C000, 24'hFF4000, 24'h00BFFD, 24'hFF4003},
    {24'h123456, 24'h000000, 24'h12340D, 24'h000000}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_scale(input logic [23:0] x, input logic [13:0] g);
    longint p;
    p = longint'($signed(x)) * longint'({1'b0, g});
    return 24'(p >>> 14);
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fs_tick = 1'b1;
      @(negedge clk) fs_tick = 1'b0;
    end
  endtask

  task automatic write_l(input logic [13:0] v);
    @(negedge clk) begin vol_req_l = v; vol_wr_l = 1'b1; end
    @(negedge clk) vol_wr_l = 1'b0;
  endtask

  task automatic send_pair(input logic [23:0] l, input logic [23:0] r);
    @(negedge clk) begin in_l = l; in_r = r; in_valid = 1'b1; end
    @(negedge clk) in_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [13:0] gl, gr;
    logic [23:0] el, er;
    repeat (3) @(negedge clk);
    check("R1 gain_l", gain_l, 14'h3FFF);
    check("R1 gain_r", gain_r, 14'h3FFF);
    check("R1 out_valid", out_valid, 0);
    check("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;

    // R9 / R10: vector walk at full-scale gain
    for (int v = 0; v < 8; v++) begin
      send_pair(VEC[v][95:72], VEC[v][71:48]);
      check("R10 out_valid", out_valid, 1);
      check("R9 out_l", out_l, VEC[v][47:24]);
      check("R9 out_r", out_r, VEC[v][23:0]);
    end
    @(negedge clk);
    check("R10 idle", out_valid, 0);

    // R3 / R6: low bits immediate, right untouched
    write_l(14'h3FF5);
    check("R3 low bits", gain_l, 14'h3FF5);
    check("R6 right kept", gain_r, 14'h3FFF);
    repeat (5) @(negedge clk);
    check("R2 no tick hold", gain_l, 14'h3FF5);

    // R2 / R4: downward ramp of 15 counts
    write_l(14'h3F00);
    check("R3 low cleared", gain_l, 14'h3FF0);
    ticks(1);
    check("R2 one step", gain_l, 14'h3FE0);
    ticks(14);
    check("R2 reach target", gain_l, 14'h3F00);
    ticks(3);
    check("R4 no overshoot", gain_l, 14'h3F00);
    check("R6 right still", gain_r, 14'h3FFF);

    // R9 at a reduced gain
    gl = gain_l; gr = gain_r;
    send_pair(24'h400000, 24'h123456);
    check("R9 scaled l", out_l, ref_scale(24'h400000, gl));
    check("R9 scaled r", out_r, ref_scale(24'h123456, gr));

    // R5: retarget mid-ramp, reversing direction
    write_l(14'h0100);
    ticks(3);
    check("R5 going down", gain_l, 14'h3ED0);
    write_l(14'h3FF7);
    check("R5 low at once", gain_l, 14'h3ED7);
    ticks(1);
    check("R5 reversed", gain_l, 14'h3EE7);
    ticks(17);
    check("R5 new target", gain_l, 14'h3FF7);
    ticks(1);
    check("R4 held", gain_l, 14'h3FF7);

    // R10: back-pressure
    gl = gain_l; gr = gain_r;
    @(negedge clk) begin out_ready = 1'b0; in_l = 24'h010000; in_r = 24'hF00000; in_valid = 1'b1; end
    @(negedge clk);
    check("R10 stalled valid", out_valid, 1);
    check("R10 stalled ready", in_ready, 0);
    el = ref_scale(24'h010000, gl);
    check("R10 first pair", out_l, el);
    in_l = 24'h020000; in_r = 24'h0F0000;
    repeat (2) @(negedge clk);
    check("R10 held l", out_l, el);
    check("R10 held r", out_r, ref_scale(24'hF00000, gr));
    out_ready = 1'b1;
    @(negedge clk) in_valid = 1'b0;
    check("R10 next l", out_l, ref_scale(24'h020000, gl));
    check("R10 next r", out_r, ref_scale(24'h0F0000, gr));
    @(negedge clk);
    check("R10 drained", out_valid, 0);

    // R7: mute ramps both channels to zero over 1023 ticks
    @(negedge clk) mute_req = 1'b1;
    @(negedge clk);
    check("R7 low l", gain_l, 14'h3FF0);
    check("R7 low r", gain_r, 14'h3FF0);
    ticks(1);
    check("R7 step r", gain_r, 14'h3FE0);
    ticks(1021);
    check("R7 one left", gain_l, 14'h0010);
    check("R7 one right", gain_r, 14'h0010);
    ticks(1);
    check("R7 zero l", gain_l, 14'h0000);
    check("R7 zero r", gain_r, 14'h0000);
    ticks(2);
    check("R7 stays zero", gain_l, 14'h0000);
    send_pair(24'h7FFFFF, 24'h800000);
    check("R7 silent l", out_l, 0);
    check("R7 silent r", out_r, 0);

    // R8: release restores low bits then ramps up
    @(negedge clk) mute_req = 1'b0;
    @(negedge clk);
    check("R8 low l", gain_l, 14'h0007);
    check("R8 low r", gain_r, 14'h000F);
    ticks(1);
    check("R8 rising", gain_r, 14'h001F);
    ticks(1022);
    check("R8 back l", gain_l, 14'h3FF7);
    check("R8 back r", gain_r, 14'h3FFF);

    // R1: reset mid-run
    write_l(14'h0123);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 rearm l", gain_l, 14'h3FFF);
    check("R1 rearm valid", out_valid, 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule